// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit sits beside a processor's pipeline control. Seven exception requests can arrive in the same cycle: system reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. The unit discards interrupt requests whose disable mask is set. It then picks the single most urgent remaining request. For that winner it reports three things: the address to jump to, the mode to enter, and the interrupt-mask values the core should load on entry.

The unit has a fixed vector layout. A configuration input chooses between a base at zero and a base at 0xFFFF0000. The results are registered, so every output appears one cycle after the requests are sampled. A one-cycle take strobe marks each cycle that carries a result. The core holds a ready input low while it cannot accept an exception, and the unit then stays idle.

Top module: `excp_arbiter`

## Requirements
- R1: While reset is applied, and in every cycle without a take, the outputs are idle: take_o = 0, vector_o = 0, mode_o = 5'b10000 (user code), irq_mask_o = 0 and fiq_mask_o = 0.
- R2: Among unmasked requests, the winner follows this ranking, strongest first: reset, data abort, FIQ, IRQ, prefetch abort, then the undefined/software-interrupt pair.
- R3: If undefined instruction and software interrupt are both asserted, and nothing stronger is present, the undefined instruction wins.
- R4: With hivec_i = 0, vector_o takes these values: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. The unit never produces offset 0x14.
- R5: With hivec_i = 1, vector_o is 0xFFFF0000 plus the same offset as in R4.
- R6: mode_o uses these codes: user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Reset and software interrupt enter supervisor. Undefined enters undefined. Both aborts enter abort. IRQ enters IRQ, and FIQ enters FIQ.
- R7: An IRQ request is ignored while irq_mask_i = 1, and an FIQ request is ignored while fiq_mask_i = 1. A masked request then gives idle outputs, or loses to the next unmasked request.
- R8: Reset, data abort and prefetch abort are taken whatever the mask inputs hold.
- R9: On a take of FIQ or reset, both irq_mask_o and fiq_mask_o are 1. On a take of any other source, irq_mask_o = 1 and fiq_mask_o = 0.
- R10: take_o is 1 in the cycle after a clock edge that sampled ready_i = 1 with at least one unmasked request. If the requests are held, it repeats every cycle. If ready_i = 0 at that edge, the outputs are idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the unit |
| ready_i | input | 1 | Core can accept an exception this cycle |
| hivec_i | input | 1 | Select the high vector base |
| irq_mask_i | input | 1 | IRQ disabled |
| fiq_mask_i | input | 1 | FIQ disabled |
| rst_req_i | input | 1 | Reset exception request |
| dabt_req_i | input | 1 | Data abort request |
| fiq_req_i | input | 1 | Fast interrupt request |
| irq_req_i | input | 1 | Normal interrupt request |
| pabt_req_i | input | 1 | Prefetch abort request |
| und_req_i | input | 1 | Undefined instruction request |
| swi_req_i | input | 1 | Software interrupt request |
| take_o | output | 1 | Exception taken this cycle |
| vector_o | output | ADDR_W | Vector address of the winner |
| mode_o | output | 5 | Mode code to enter |
| irq_mask_o | output | 1 | IRQ mask value on entry |
| fiq_mask_o | output | 1 | FIQ mask value on entry |

## Verification
The hardest case to reach from the ports is a masked interrupt that sits beside a weaker request. An example is FIQ masked while IRQ and a prefetch abort are pending. If the mask is honoured, IRQ must win. If the mask is ignored, FIQ is chosen instead. The stimulus builds such mixed request sets on purpose. It also repeats the ranking sweeps at the high vector base, so that base selection and arbitration are checked together.

// File: rtl/excp_pkg.sv
package excp_pkg;

   // Sources, indexed by rank (0 = most urgent)
   localparam int unsigned NSRC = 7;

   typedef enum logic [2:0] {
      SRC_RST  = 3'd0,
      SRC_DABT = 3'd1,
      SRC_FIQ  = 3'd2,
      SRC_IRQ  = 3'd3,
      SRC_PABT = 3'd4,
      SRC_UND  = 3'd5,
      SRC_SWI  = 3'd6
   } src_e;

   typedef enum logic [4:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } mode_e;

   localparam int unsigned OFS_W = 5;

   function automatic logic [OFS_W-1:0] vec_offset(src_e s);
      case (s)
         SRC_RST:  return 5'h00;
         SRC_UND:  return 5'h04;
         SRC_SWI:  return 5'h08;
         SRC_PABT: return 5'h0C;
         SRC_DABT: return 5'h10;
         SRC_IRQ:  return 5'h18;
         SRC_FIQ:  return 5'h1C;
         default:  return 5'h00;
      endcase
   endfunction

   function automatic mode_e entry_mode(src_e s);
      case (s)
         SRC_RST, SRC_SWI:   return MODE_SVC;
         SRC_UND:            return MODE_UND;
         SRC_PABT, SRC_DABT: return MODE_ABT;
         SRC_IRQ:            return MODE_IRQ;
         SRC_FIQ:            return MODE_FIQ;
         default:            return MODE_USR;
      endcase
   endfunction

endpackage

// File: rtl/excp_mask_filter.sv
module excp_mask_filter
   import excp_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_mask_i,
   input  logic            fiq_mask_i,
   input  logic            rst_req_i,
   input  logic            dabt_req_i,
   input  logic            fiq_req_i,
   input  logic            irq_req_i,
   input  logic            pabt_req_i,
   input  logic            und_req_i,
   input  logic            swi_req_i,
   output logic [NSRC-1:0] live_o
);

   always_comb begin
      live_o           = '0;
      live_o[SRC_RST]  = rst_req_i;
      live_o[SRC_DABT] = dabt_req_i;
      live_o[SRC_FIQ]  = fiq_req_i & ~fiq_mask_i;
      live_o[SRC_IRQ]  = irq_req_i & ~irq_mask_i;
      live_o[SRC_PABT] = pabt_req_i;
      live_o[SRC_UND]  = und_req_i;
      live_o[SRC_SWI]  = swi_req_i;
   end

   AST_MASK_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_mask_i |-> !live_o[SRC_FIQ]); // R7
   AST_MASK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mask_i |-> !live_o[SRC_IRQ]); // R7
   AST_ABORT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (dabt_req_i || pabt_req_i || rst_req_i) |-> (live_o[SRC_DABT] | live_o[SRC_PABT] | live_o[SRC_RST])); // R8

endmodule

// File: rtl/excp_prio_pick.sv
module excp_prio_pick
   import excp_pkg::*;
#(
   parameter int unsigned N     = NSRC,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req_i,
   output logic [N-1:0]     grant_o,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   if (N < 2) begin : g_chk_n
      $error("excp_prio_pick: N must be at least 2");
   end

   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_rank
      assign grant_o[i]    = req_i[i] & ~blocked[i];
      assign blocked[i+1]  = blocked[i] | req_i[i];
   end

   assign any_o = blocked[N];

   always_comb begin
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (grant_o[k]) idx_o = IDX_W'(k);
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o)); // R2
   AST_GRANT_IF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_i) |-> ($countones(grant_o) == 1)); // R2
   AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[0] |-> grant_o[0]); // R2

endmodule

// File: rtl/excp_vector_map.sv
module excp_vector_map
   import excp_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 32,
   parameter logic [ADDR_W-1:0]  LOW_BASE = '0,
   parameter logic [ADDR_W-1:0]  HIGH_BASE = 32'hFFFF_0000,
   parameter bit                 HIVEC_EN = 1'b1
)(
   input  src_e              src_i,
   input  logic              hivec_i,
   output logic [ADDR_W-1:0] vec_o,
   output mode_e             mode_o
);

   localparam int unsigned PAD_W = ADDR_W - OFS_W;

   if (ADDR_W < 8) begin : g_chk_w
      $error("excp_vector_map: ADDR_W too small");
   end
   if (LOW_BASE[OFS_W-1:0] != '0 || HIGH_BASE[OFS_W-1:0] != '0) begin : g_chk_base
      $error("excp_vector_map: base not aligned to the vector table");
   end

   logic [ADDR_W-1:0] base;

   if (HIVEC_EN) begin : g_hivec
      assign base = hivec_i ? HIGH_BASE : LOW_BASE;
   end else begin : g_lovec
      logic unused_hi;
      assign unused_hi = hivec_i;
      assign base      = LOW_BASE;
   end

   assign vec_o  = base | {{PAD_W{1'b0}}, vec_offset(src_i)};
   assign mode_o = entry_mode(src_i);

endmodule

// File: rtl/excp_arbiter.sv
module excp_arbiter
   import excp_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]  LOW_BASE  = '0,
   parameter logic [ADDR_W-1:0]  HIGH_BASE = 32'hFFFF_0000,
   parameter bit                 HIVEC_EN  = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready_i,
   input  logic              hivec_i,
   input  logic              irq_mask_i,
   input  logic              fiq_mask_i,
   input  logic              rst_req_i,
   input  logic              dabt_req_i,
   input  logic              fiq_req_i,
   input  logic              irq_req_i,
   input  logic              pabt_req_i,
   input  logic              und_req_i,
   input  logic              swi_req_i,
   output logic              take_o,
   output logic [ADDR_W-1:0] vector_o,
   output logic [4:0]        mode_o,
   output logic              irq_mask_o,
   output logic              fiq_mask_o
);

   localparam int unsigned IDX_W = $clog2(NSRC);

   logic [NSRC-1:0]   live;
   logic [NSRC-1:0]   grant;
   logic              any_live;
   logic [IDX_W-1:0]  win_idx;
   src_e              win_src;
   logic [ADDR_W-1:0] win_vec;
   mode_e             win_mode;
   logic              fire;

   excp_mask_filter u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_mask_i (irq_mask_i),
      .fiq_mask_i (fiq_mask_i),
      .rst_req_i  (rst_req_i),
      .dabt_req_i (dabt_req_i),
      .fiq_req_i  (fiq_req_i),
      .irq_req_i  (irq_req_i),
      .pabt_req_i (pabt_req_i),
      .und_req_i  (und_req_i),
      .swi_req_i  (swi_req_i),
      .live_o     (live)
   );

   excp_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (live),
      .grant_o (grant),
      .any_o   (any_live),
      .idx_o   (win_idx)
   );

   assign win_src = src_e'(win_idx);

   excp_vector_map #(
      .ADDR_W    (ADDR_W),
      .LOW_BASE  (LOW_BASE),
      .HIGH_BASE (HIGH_BASE),
      .HIVEC_EN  (HIVEC_EN)
   ) u_map (
      .src_i   (win_src),
      .hivec_i (hivec_i),
      .vec_o   (win_vec),
      .mode_o  (win_mode)
   );

   assign fire = any_live & ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o     <= 1'b0;
         vector_o   <= '0;
         mode_o     <= MODE_USR;
         irq_mask_o <= 1'b0;
         fiq_mask_o <= 1'b0;
      end else if (fire) begin
         take_o     <= 1'b1;
         vector_o   <= win_vec;
         mode_o     <= win_mode;
         irq_mask_o <= 1'b1;
         fiq_mask_o <= grant[SRC_FIQ] | grant[SRC_RST];
      end else begin
         take_o     <= 1'b0;
         vector_o   <= '0;
         mode_o     <= MODE_USR;
         irq_mask_o <= 1'b0;
         fiq_mask_o <= 1'b0;
      end
   end

   AST_NO_RSVD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (vector_o[4:0] != 5'h14)); // R4
   AST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |=> !take_o); // R10
   AST_FIQ_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && mode_o == MODE_FIQ) |-> (irq_mask_o && fiq_mask_o)); // R9
   AST_ENTRY_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> irq_mask_o); // R9
   AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (vector_o == '0 && mode_o == MODE_USR && !irq_mask_o && !fiq_mask_o)); // R1
   AST_MASKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask_i && fiq_mask_i && !rst_req_i && !dabt_req_i && !pabt_req_i
       && !und_req_i && !swi_req_i) |=> !take_o); // R7
   AST_RESET_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_i && ready_i) |=> (take_o && mode_o == MODE_SVC)); // R8

endmodule

// File: tb/sim_excp_arbiter.sv
module sim_excp_arbiter;

   typedef struct {
      logic        take;
      logic [31:0] vec;
      logic [4:0]  mode;
      logic        mi;
      logic        mf;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ready_i = 1'b0, hivec_i = 1'b0, irq_mask_i = 1'b0, fiq_mask_i = 1'b0;
   logic rst_req_i = 1'b0, dabt_req_i = 1'b0, fiq_req_i = 1'b0, irq_req_i = 1'b0;
   logic pabt_req_i = 1'b0, und_req_i = 1'b0, swi_req_i = 1'b0;
   logic        take_o;
   logic [31:0] vector_o;
   logic [4:0]  mode_o;
   logic        irq_mask_o, fiq_mask_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   excp_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .hivec_i(hivec_i),
      .irq_mask_i(irq_mask_i), .fiq_mask_i(fiq_mask_i),
      .rst_req_i(rst_req_i), .dabt_req_i(dabt_req_i), .fiq_req_i(fiq_req_i),
      .irq_req_i(irq_req_i), .pabt_req_i(pabt_req_i), .und_req_i(und_req_i),
      .swi_req_i(swi_req_i), .take_o(take_o), .vector_o(vector_o),
      .mode_o(mode_o), .irq_mask_o(irq_mask_o), .fiq_mask_o(fiq_mask_o)
   );

   // r order: {swi,und,pabt,irq,fiq,dabt,rst} as bits 6..0 (bit 0 = reset)
   task automatic apply(input logic [6:0] r, input logic mi, input logic mf,
                        input logic hv, input logic rdy, input string tag);
      exp_t e;
      logic [6:0] u;
      int w;
      @(negedge clk);
      rst_req_i = r[0]; dabt_req_i = r[1]; fiq_req_i = r[2]; irq_req_i = r[3];
      pabt_req_i = r[4]; und_req_i = r[5]; swi_req_i = r[6];
      irq_mask_i = mi; fiq_mask_i = mf; hivec_i = hv; ready_i = rdy;
      u = r;
      if (mf) u[2] = 1'b0;
      if (mi) u[3] = 1'b0;
      w = -1;
      if      (u[0]) w = 0;
      else if (u[1]) w = 1;
      else if (u[2]) w = 2;
      else if (u[3]) w = 3;
      else if (u[4]) w = 4;
      else if (u[5]) w = 5;
      else if (u[6]) w = 6;
      e.tag = tag;
      if (w < 0 || !rdy) begin
         e.take = 0; e.vec = 0; e.mode = 5'b10000; e.mi = 0; e.mf = 0;
      end else begin
         e.take = 1;
         e.mi = 1;
         e.mf = (w == 0 || w == 2);
         case (w)
            0: begin e.vec = 32'h00; e.mode = 5'b10011; end
            1: begin e.vec = 32'h10; e.mode = 5'b10111; end
            2: begin e.vec = 32'h1C; e.mode = 5'b10001; end
            3: begin e.vec = 32'h18; e.mode = 5'b10010; end
            4: begin e.vec = 32'h0C; e.mode = 5'b10111; end
            5: begin e.vec = 32'h04; e.mode = 5'b11011; end
            default: begin e.vec = 32'h08; e.mode = 5'b10011; end
         endcase
         if (hv) e.vec = e.vec | 32'hFFFF_0000;
      end
      q.push_back(e);
   endtask

   // Monitor: compare after each edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (take_o !== e.take || vector_o !== e.vec || mode_o !== e.mode ||
             irq_mask_o !== e.mi || fiq_mask_o !== e.mf) begin
            errors++;
            $display("FAIL %s: got take=%0b vec=%h mode=%b mi=%0b mf=%0b exp take=%0b vec=%h mode=%b mi=%0b mf=%0b",
                     e.tag, take_o, vector_o, mode_o, irq_mask_o, fiq_mask_o,
                     e.take, e.vec, e.mode, e.mi, e.mf);
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++; // R1 reset state
      if (take_o !== 0 || vector_o !== 0 || mode_o !== 5'b10000 ||
          irq_mask_o !== 0 || fiq_mask_o !== 0) begin
         errors++;
         $display("FAIL R1: got take=%0b vec=%h mode=%b exp idle", take_o, vector_o, mode_o);
      end
      rst_n = 1'b1;

      // R4/R6/R9: each source alone, low base; R5 at high base
      for (int hv = 0; hv < 2; hv++) begin
         for (int s = 0; s < 7; s++) begin
            apply(7'(1 << s), 0, 0, hv[0], 1, hv ? "R5 single source" : "R4 R6 R9 single source");
         end
      end
      // R2 ranking sweep: drop the strongest one at a time, both bases
      for (int hv = 0; hv < 2; hv++) begin
         for (int s = 0; s < 7; s++) begin
            apply(7'h7F << s, 0, 0, hv[0], 1, "R2 ranking");
         end
      end
      apply(7'b1100000, 0, 0, 0, 1, "R3 und over swi");
      apply(7'b1100000, 1, 1, 1, 1, "R3 und over swi high");
      // R7 masking
      apply(7'b0001000, 1, 0, 0, 1, "R7 irq masked");
      apply(7'b0000100, 0, 1, 0, 1, "R7 fiq masked");
      apply(7'b0011100, 0, 1, 0, 1, "R7 fiq masked irq wins");
      apply(7'b0011100, 1, 1, 0, 1, "R7 both masked pabt wins");
      apply(7'b0001100, 1, 1, 1, 1, "R7 both masked idle");
      apply(7'b0001000, 0, 1, 0, 1, "R7 fiq mask leaves irq");
      // R8 unmaskable
      apply(7'b0000010, 1, 1, 0, 1, "R8 dabt masks set");
      apply(7'b0010000, 1, 1, 1, 1, "R8 pabt masks set");
      apply(7'b0000001, 1, 1, 0, 1, "R8 reset masks set");
      // R10 ready gating and repeated strobe
      apply(7'b0000001, 0, 0, 0, 0, "R10 not ready");
      apply(7'b0000100, 0, 0, 0, 1, "R10 held 1");
      apply(7'b0000100, 0, 0, 0, 1, "R10 held 2");
      apply(7'b0000100, 0, 0, 0, 0, "R10 drop ready");
      apply(7'b0000000, 0, 0, 0, 1, "R1 idle no request");
      apply(7'b0000000, 0, 0, 0, 0, "R1 drain");
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule